// File: doc/BRIEF.md
# Dual-Rate Serial Transmit Front End

This block takes parallel transmit words from a source that runs on its own word clock. It sends each word out one bit at a time on a bit clock that runs ten bit periods per word slot. Everything inside runs on the bit clock. The word clock enters as a sampled signal and is never used as a clock.

After reset, the block watches the word clock through a synchronizer. On the first qualifying edge it records a phase point within the ten-cycle slot, and that point stays fixed until the next reset. The qualifying edge depends on the rate mode:

- In half-rate mode only a falling edge counts, and one word is taken per word-clock period.
- In full-rate mode either edge counts. The word clock is then twice the slot length, so one word is taken in its high phase and one in its low phase.

Each symbol comes from one of three sources:

- a raw 10-bit word;
- an 8-bit word passed to an external encoder, whose 10-bit answer is sent;
- an internal pseudo-random generator used for loopback testing.

Words enter over a valid/ready handshake. `in_ready` is a one-cycle pulse, once per slot. A word transfers only in a cycle where `in_valid` and `in_ready` are both high. The source must hold `in_data` and `in_valid` until that cycle. If no word is offered in a slot, an idle symbol is sent instead. Nothing is ever dropped or repeated.

Top module: `txser_front`

## Requirements
- R1: While reset is asserted, `link_up` and `in_ready` are 0 and `sout` is 1, the idle line level.
- R2: Each symbol is shifted out least-significant bit first, one bit per clock, ten bits per symbol, back to back with no gap. Bit 0 appears on `sout` two clock cycles after the cycle in which the handshake (or slot capture) took place.
- R3: In half-rate mode (`full_rate`=0) with a word clock of period ten bit cycles, every `in_ready` pulse is sampled exactly two bit cycles after the most recent falling edge of `wclk`. `in_ready` stays 0 until that alignment is reached.
- R4: In full-rate mode (`full_rate`=1) with a word clock of period twenty bit cycles, either edge of `wclk` locks the slot phase. Two words are taken per word-clock period, and every `in_ready` pulse comes two bit cycles after the most recent `wclk` edge.
- R5: With `mode8`=0 and `prbs_on`=0, an accepted `in_data[9:0]` is sent unchanged.
- R6: Once locked, the slot phase never moves. A later phase shift of `wclk` changes neither the `in_ready` cadence nor the serial timing.
- R7: With `prbs_on`=1, each slot sends ten generator bits. The generator is an 8-bit LFSR with polynomial x^8+x^6+x^5+x^4+1 and seed 0x01 at reset. Each bit is the current state bit 7; the state then shifts left, taking bit7^bit5^bit4^bit3 into bit 0. The LFSR advances only in slots where it supplies the symbol.
- R8: While `prbs_on`=1, `in_ready` stays 0 and `in_valid`/`in_data` have no effect on `sout`.
- R9: With `mode8`=1, `enc_word` equals `in_data[7:0]`, and the symbol sent is the `enc_sym` value present in the handshake cycle.
- R10: `link_up` rises in the cycle that shows the first bit of the first symbol and then stays 1. Before that, `sout` holds 1.
- R11: A slot with no handshake (`in_valid`=0) sends the idle symbol 10'h17C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset; alignment runs after release |
| wclk | input | 1 | Word clock, sampled as data; same period as the reference, arbitrary phase |
| full_rate | input | 1 | 1: both word-clock phases carry a word; 0: falling edge only; static while out of reset |
| mode8 | input | 1 | 1: send the external encoder's answer for an 8-bit word |
| prbs_on | input | 1 | 1: the internal generator replaces user data |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | One-cycle slot pulse; transfer when high with in_valid |
| in_data | input | 10 | Parallel word; bits 7:0 only in 8-bit mode |
| enc_word | output | 8 | Raw byte handed to the external encoder |
| enc_sym | input | 10 | Encoder answer, combinational from enc_word |
| sout | output | 1 | Serial data, LSB first |
| link_up | output | 1 | Serial stream running |

## Verification
The assertions take the following for granted:

- `wclk` has a steady period that is a multiple of the slot length.
- `full_rate` does not change while out of reset.
- `enc_sym` settles within the cycle it is sampled.

The load-spacing and lock-stability checks depend on these. The stimulus builds `wclk` from a counter stepped on the falling bit-clock edge, so its period is exactly ten or twenty cycles. The only phase disturbance is a deliberate stall after lock. Mode inputs change only between resets or on a falling edge, and the encoder model is a pure combinational function of `enc_word`.

// File: rtl/txser_pkg.sv
package txser_pkg;
  typedef enum logic [1:0] {
    AL_ARM  = 2'd0,
    AL_SEEK = 2'd1,
    AL_LOCK = 2'd2
  } align_state_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/txser_align.sv
module txser_align
  import txser_pkg::*;
#(
  parameter int unsigned SYM_W       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wclk_i,
  input  logic full_rate_i,
  output logic cap_o,
  output logic locked_o
);
  localparam int unsigned ARM_N = SYNC_STAGES + 1;
  localparam int unsigned ARM_W = cnt_w(ARM_N + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [ARM_W-1:0]       arm_cnt;
  logic [CNT_W-1:0]       bit_cnt;
  logic [CNT_W-1:0]       lock_pt;
  align_state_e           st;
  logic                   sync_last;
  logic                   edge_hit;

  assign sync_last = sync_q[SYNC_STAGES-1];
  // half rate: falling edge only; full rate: any edge
  assign edge_hit  = full_rate_i ? (prev_q ^ sync_last) : (prev_q & ~sync_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wclk_i};
      prev_q <= sync_last;
    end
  end

  // free-running slot position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_cnt <= '0;
    else if (bit_cnt == CNT_W'(SYM_W - 1)) bit_cnt <= '0;
    else bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= AL_ARM;
      arm_cnt <= '0;
      lock_pt <= '0;
    end else begin
      unique case (st)
        AL_ARM: begin
          arm_cnt <= arm_cnt + 1'b1;
          if (arm_cnt == ARM_W'(ARM_N - 1)) st <= AL_SEEK;
        end
        AL_SEEK: begin
          if (edge_hit) begin
            lock_pt <= bit_cnt;
            st      <= AL_LOCK;
          end
        end
        default: st <= AL_LOCK;  // locked: never revisits the edge detector
      endcase
    end
  end

  assign locked_o = (st == AL_LOCK);
  assign cap_o    = locked_o && (bit_cnt == lock_pt);

  assert_lock_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == AL_LOCK) |=> (st == AL_LOCK) && $stable(lock_pt));
endmodule

// File: rtl/txser_prbs.sv
module txser_prbs #(
  parameter int unsigned       SYM_W  = 10,
  parameter int unsigned       LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS   = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED   = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [SYM_W-1:0] sym_o
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] chain [SYM_W+1];

  assign chain[0] = state;

  // one shift per symbol bit, unrolled over the slot
  for (genvar g = 0; g < SYM_W; g++) begin : g_step
    assign sym_o[g]    = chain[g][LFSR_W-1];
    assign chain[g+1]  = {chain[g][LFSR_W-2:0], ^(chain[g] & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else if (step_i) state <= chain[SYM_W];
  end

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/txser_shift.sv
module txser_shift
  import txser_pkg::*;
#(
  parameter int unsigned SYM_W      = 10,
  parameter logic        IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             sout_o,
  output logic             link_o
);
  localparam int unsigned GAP_W = cnt_w(SYM_W) + 1;

  logic [SYM_W-1:0] hold_q;
  logic [SYM_W-1:0] shreg;
  logic             load_q;
  logic             link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      load_q <= 1'b0;
      shreg  <= '0;
      link_q <= 1'b0;
    end else begin
      if (cap_i) hold_q <= sym_i;
      load_q <= cap_i;
      if (load_q) begin
        shreg  <= hold_q;
        link_q <= 1'b1;
      end else begin
        shreg <= shreg >> 1;
      end
    end
  end

  assign sout_o = link_q ? shreg[0] : IDLE_LEVEL;
  assign link_o = link_q;

  // load spacing watch: reloads must be exactly one slot apart
  logic [GAP_W-1:0] gap;
  logic             primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap    <= '0;
      primed <= 1'b0;
    end else if (load_q) begin
      gap    <= '0;
      primed <= 1'b1;
    end else if (gap != '1) begin
      gap <= gap + 1'b1;
    end
  end

  assert_load_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_q && primed) |-> (gap == GAP_W'(SYM_W - 1)));
endmodule

// File: rtl/txser_front.sv
module txser_front
  import txser_pkg::*;
#(
  parameter int unsigned       SYM_W       = 10,
  parameter int unsigned       RAW_W       = 8,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       LFSR_W      = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS   = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED   = 8'h01,
  parameter logic [SYM_W-1:0]  IDLE_SYM    = 10'h17C,
  parameter logic              IDLE_LEVEL  = 1'b1
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             full_rate,
  input  logic             mode8,
  input  logic             prbs_on,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  output logic [RAW_W-1:0] enc_word,
  input  logic [SYM_W-1:0] enc_sym,
  output logic             sout,
  output logic             link_up
);
  localparam int unsigned CNT_W = cnt_w(SYM_W);

  logic             cap;
  logic             locked;
  logic [SYM_W-1:0] prbs_sym;
  logic [SYM_W-1:0] user_sym;
  logic [SYM_W-1:0] sym_sel;

  txser_align #(
    .SYM_W(SYM_W), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) u_align (
    .clk(clk_bit), .rst_n(rst_n), .wclk_i(wclk), .full_rate_i(full_rate),
    .cap_o(cap), .locked_o(locked)
  );

  txser_prbs #(
    .SYM_W(SYM_W), .LFSR_W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_prbs (
    .clk(clk_bit), .rst_n(rst_n), .step_i(cap && prbs_on), .sym_o(prbs_sym)
  );

  assign enc_word = in_data[RAW_W-1:0];
  assign user_sym = mode8 ? enc_sym : in_data;

  always_comb begin
    if (prbs_on)       sym_sel = prbs_sym;
    else if (in_valid) sym_sel = user_sym;
    else               sym_sel = IDLE_SYM;
  end

  assign in_ready = cap && !prbs_on;

  txser_shift #(
    .SYM_W(SYM_W), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_shift (
    .clk(clk_bit), .rst_n(rst_n), .cap_i(cap), .sym_i(sym_sel),
    .sout_o(sout), .link_o(link_up)
  );

  assert_link_sticky_R10: assert property (@(posedge clk_bit) disable iff (!rst_n)
    link_up |=> link_up);

  assert_link_after_capture_R10: assert property (@(posedge clk_bit) disable iff (!rst_n)
    $rose(link_up) |-> ($past(cap, 2) && locked));
endmodule

// File: tb/txser_front_bench.sv
module txser_front_bench;
  logic       clk_bit = 1'b0;
  logic       rst_n = 1'b0;
  logic       wclk = 1'b0;
  logic       full_rate = 1'b0;
  logic       mode8 = 1'b0;
  logic       prbs_on = 1'b0;
  logic       in_valid = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_ready;
  logic [7:0] enc_word;
  logic [9:0] enc_sym;
  logic       sout;
  logic       link_up;

  always #5 clk_bit = ~clk_bit;

  // external encoder stand-in
  function automatic logic [9:0] enc_model(input logic [7:0] w);
    return {^w, ~w[0], w};
  endfunction
  assign enc_sym = enc_model(enc_word);

  txser_front u_txser_front (
    .clk_bit(clk_bit), .rst_n(rst_n), .wclk(wclk), .full_rate(full_rate),
    .mode8(mode8), .prbs_on(prbs_on), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .enc_word(enc_word), .enc_sym(enc_sym),
    .sout(sout), .link_up(link_up)
  );

  int    vectors = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R2";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // word clock generator
  int wc_period = 10;
  int wc_pos = 0;
  int wc_stall = 0;
  always @(negedge clk_bit) begin
    if (wc_stall > 0) wc_stall--;
    else begin
      wc_pos = (wc_pos + 1) % wc_period;
      wclk = (wc_pos < wc_period / 2);
    end
  end

  // scoreboard, sampled 1 ns after the falling edge
  int         idx = 0;
  bit         prev_w = 0;
  int         last_fall = -100;
  int         last_any = -100;
  bit         align_chk = 0;
  bit         slot_run = 0;
  int         slot = 0;
  bit         started = 0;
  int         start_idx = 0;
  bit         accepted = 0;
  bit         q[$];
  logic [7:0] mlfsr = 8'h01;

  always @(negedge clk_bit) begin
    #1;
    idx++;
    if (!rst_n) begin
      slot_run = 0; started = 0; q.delete(); mlfsr = 8'h01;
      prev_w = wclk; last_fall = -100; last_any = -100;
    end else begin
      logic [9:0] sym;
      bit exp_link;
      if (wclk != prev_w) begin
        last_any = idx;
        if (!wclk) last_fall = idx;
      end
      prev_w = wclk;
      if (!slot_run && in_ready) begin
        slot_run = 1;
        slot = 0;
      end
      if (slot_run) begin
        chk(in_ready == (slot == 0 && !prbs_on), prbs_on ? "R8" : "R6", in_ready, slot == 0 && !prbs_on);
        if (slot == 0) begin
          if (align_chk && !prbs_on) begin
            if (full_rate) chk(idx - last_any == 2, "R4", idx - last_any, 2);
            else           chk(idx - last_fall == 2, "R3", idx - last_fall, 2);
          end
          if (prbs_on) begin
            for (int b = 0; b < 10; b++) begin
              sym[b] = mlfsr[7];
              mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
            end
          end else if (in_valid) begin
            if (mode8) begin
              chk(enc_word == in_data[7:0], "R9", enc_word, in_data[7:0]);
              sym = enc_model(in_data[7:0]);
            end else sym = in_data;
            accepted = 1;
          end else sym = 10'h17C;  // R11 idle symbol
          for (int b = 0; b < 10; b++) q.push_back(sym[b]);
          if (!started) begin
            started = 1;
            start_idx = idx + 2;
          end
        end
        slot = (slot + 1) % 10;
      end else begin
        chk(in_ready == 1'b0, "R3", in_ready, 0);
      end
      exp_link = started && (idx >= start_idx);
      chk(link_up == exp_link, "R10", link_up, exp_link);
      if (exp_link) begin
        bit eb;
        if (q.size() == 0) chk(0, "R2", 0, 1);
        else begin
          eb = q.pop_front();
          chk(sout == eb, cur_req, sout, eb);  // R2 ordering and timing
        end
      end else begin
        chk(sout == 1'b1, "R10", sout, 1);
      end
    end
  end

  task automatic do_reset(input bit full, input int phase);
    @(negedge clk_bit);
    rst_n = 0; in_valid = 0; prbs_on = 0; mode8 = 0;
    full_rate = full;
    wc_period = full ? 20 : 10;
    wc_pos = phase;
    align_chk = 1;
    repeat (3) @(negedge clk_bit);
    #2;
    chk(link_up == 0, "R1", link_up, 0);
    chk(in_ready == 0, "R1", in_ready, 0);
    chk(sout == 1, "R1", sout, 1);
    @(negedge clk_bit);
    rst_n = 1;
  endtask

  task automatic push_word(input logic [9:0] w);
    @(negedge clk_bit);
    accepted = 0;
    in_valid = 1;
    in_data = w;
    do @(negedge clk_bit); while (!accepted);
    in_valid = 0;
  endtask

  task automatic t_reset_state;
    do_reset(0, 3);
    repeat (5) @(negedge clk_bit);
  endtask

  task automatic t_half_10b;
    cur_req = "R2";
    for (int i = 0; i < 6; i++) push_word(10'(i * 97 + 1));
    cur_req = "R5";
    for (int i = 0; i < 10; i++) push_word(10'($urandom));
    cur_req = "R11";
    repeat (35) @(negedge clk_bit);
    push_word(10'h3FF);
    repeat (30) @(negedge clk_bit);
  endtask

  task automatic t_enc_8b;
    @(negedge clk_bit);
    mode8 = 1;
    cur_req = "R9";
    for (int i = 0; i < 12; i++) push_word({2'b11, 8'($urandom)});
    @(negedge clk_bit);
    mode8 = 0;
    repeat (25) @(negedge clk_bit);
  endtask

  task automatic t_prbs;
    @(negedge clk_bit);
    cur_req = "R7";
    prbs_on = 1;
    repeat (200) @(negedge clk_bit);
    cur_req = "R8";
    in_valid = 1; in_data = 10'h000;
    repeat (400) @(negedge clk_bit);
    in_valid = 0;
    prbs_on = 0;
    cur_req = "R5";
    for (int i = 0; i < 4; i++) push_word(10'(i + 500));
    repeat (25) @(negedge clk_bit);
  endtask

  task automatic t_no_realign;
    @(negedge clk_bit);
    align_chk = 0;
    wc_stall = 3;
    cur_req = "R6";
    for (int i = 0; i < 10; i++) push_word(10'($urandom));
    repeat (25) @(negedge clk_bit);
  endtask

  task automatic t_full_rate;
    int rdy;
    int falls;
    bit pw;
    do_reset(1, 7);
    cur_req = "R4";
    for (int i = 0; i < 8; i++) push_word(10'($urandom));
    rdy = 0; falls = 0; pw = wclk;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk_bit);
      #2;
      if (in_ready) rdy++;
      if (pw && !wclk) falls++;
      pw = wclk;
    end
    chk(rdy == 2 * falls, "R4", rdy, 2 * falls);
    for (int i = 0; i < 8; i++) push_word(10'($urandom));
    repeat (25) @(negedge clk_bit);
  endtask

  initial begin
    t_reset_state();
    t_half_10b();
    t_enc_8b();
    t_prbs();
    t_no_realign();
    t_full_rate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_bit);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule